// File: doc/BRIEF.md
# Match-Compare System Timer

The block is a memory-mapped system timer. A single 32-bit up-counter advances by one on every cycle where the tick-enable input is high, and four 32-bit compare registers are checked against it. When a tick carries the counter onto a compare value, that channel records an event and drives its own interrupt line, provided software has enabled that channel. Compare channel 3 can also serve as a one-shot watchdog: when it is armed and channel 3 matches, the block emits a reset-request pulse and disarms itself.

Software reaches the block through a simple register bus. A single-cycle write strobe carries a word offset and 32-bit data. A single-cycle read strobe returns registered data one cycle later. Event bits are cleared by writing ones. Reads of unmapped words return zero and flag an error. Clock generation and interrupt routing sit outside the block.

Top module: `ost_timer_core`

## Requirements
- R1: After reset the counter, all compare registers, the status register, the interrupt-enable register, the watchdog arm bit, every interrupt line, the reset-request output and the read error flag are zero.
- R2: A write to the counter word loads the written value. Each later cycle with the tick input high adds one, modulo 2^32. A load in the same cycle as a tick takes priority over the tick. With the tick low and no load, the value holds.
- R3: Channel n fires when a tick moves the counter from one value to a value equal to compare register n. If interrupt-enable bit n is 1, status bit n (bit n = channel n) becomes 1 and interrupt line n goes high on the same edge. If the enable bit is 0, nothing is recorded.
- R4: A channel fires once for each equality. It does not fire while the counter rests on the compare value, on later ticks, or when the counter is loaded directly with the compare value.
- R5: Writing the status word clears each status bit written as 1, and its interrupt line falls with it. Bits written as 0 are unchanged. A new event in the same cycle as a clear leaves the bit set.
- R6: The interrupt-enable word stores only bits 11:0. A read returns those bits with bits 31:12 zero.
- R7: When watchdog bit 0 is 1 and channel 3 fires, with or without its interrupt enabled, the reset-request output is high for exactly one cycle and the watchdog word becomes zero. Matches on other channels, and channel 3 matches while the watchdog is disarmed, issue no request.
- R8: A read of any word offset from 8 upward returns zero with the error flag high for the one cycle that the data is presented. Mapped reads leave the flag low.
- R9: Word offsets: compare register n at word n (byte 4n) for n = 0..3, counter at word 4, status at word 5, watchdog at word 6 (only bit 0 stored), interrupt enable at word 7. Read data appears on the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count enable, one increment per high cycle |
| wr_en_i | input | 1 | Single-cycle write strobe |
| rd_en_i | input | 1 | Single-cycle read strobe |
| addr_i | input | ADDR_W (4) | Word offset |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Registered read data |
| rd_err_o | output | 1 | Unmapped-read flag, aligned with rdata_o |
| irq_o | output | NUM_CH (4) | Per-channel interrupt lines |
| rst_req_o | output | 1 | Single-cycle watchdog reset request |

## Verification
On every cycle the assertions check the counter step and hold rule, the rule that an interrupt can rise only under its enable bit, clear-by-one on status, the 12-bit enable store, the single-cycle reset request together with the disarm, and the rule that an error flag follows only a read strobe. Some behaviour is visible only in the bench's scenarios: which channel fires for a given enable pattern (a sweep over every channel and all sixteen enable masks), the wrap from all ones to zero, once-per-equality firing, a set that wins over a same-cycle clear, and the absence of a second watchdog request after disarm.

// File: rtl/ost_pkg.sv
package ost_pkg;
  // word offsets of the register file; compare register n sits at word n
  localparam int WORD_COUNT  = 4;
  localparam int WORD_STATUS = 5;
  localparam int WORD_WDOG   = 6;
  localparam int WORD_IEN    = 7;
  localparam int WORDS_MAPPED = 8;
endpackage

// File: rtl/ost_counter.sv
module ost_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic [DATA_W-1:0] step_val_o,
  output logic              step_en_o
);
  logic [DATA_W-1:0] cnt_q;

  assign step_val_o = cnt_q + DATA_W'(1);
  assign step_en_o  = tick_i & ~load_i;
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)            cnt_q <= '0;
    else if (load_i)    cnt_q <= load_val_i;
    else if (step_en_o) cnt_q <= step_val_o;
  end
endmodule

// File: rtl/ost_match_ch.sv
module ost_match_ch #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] step_val_i,
  input  logic              step_en_i,
  output logic [DATA_W-1:0] match_o,
  output logic              hit_o
);
  logic [DATA_W-1:0] match_q;

  // a hit is the step that lands on the compare value
  assign hit_o   = step_en_i & (step_val_i == match_q);
  assign match_o = match_q;

  always_ff @(posedge clk) begin
    if (rst)       match_q <= '0;
    else if (wr_i) match_q <= wdata_i;
  end
endmodule

// File: rtl/ost_event_ctrl.sv
module ost_event_ctrl #(
  parameter int NUM_CH  = 4,
  parameter int IE_W    = 12,
  parameter int WDOG_CH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] hit_i,
  input  logic              ie_wr_i,
  input  logic              st_wr_i,
  input  logic              wdog_wr_i,
  input  logic [IE_W-1:0]   wdata_i,
  output logic [IE_W-1:0]   ie_o,
  output logic [NUM_CH-1:0] status_o,
  output logic              wdog_o,
  output logic              rst_req_o
);
  logic [IE_W-1:0]   ie_q;
  logic [NUM_CH-1:0] status_q;
  logic              wdog_q;
  logic              rst_req_q;
  logic              wdog_fire;

  assign wdog_fire = hit_i[WDOG_CH] & wdog_q;

  always_ff @(posedge clk) begin
    if (rst) ie_q <= '0;
    else if (ie_wr_i) ie_q <= wdata_i;
  end

  // per channel: clear by one, a gated event wins over a clear
  for (genvar g = 0; g < NUM_CH; g++) begin : g_stat
    logic clr;
    assign clr = st_wr_i & wdata_i[g];
    always_ff @(posedge clk) begin
      if (rst) status_q[g] <= 1'b0;
      else     status_q[g] <= (status_q[g] & ~clr) | (hit_i[g] & ie_q[g]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wdog_q    <= 1'b0;
      rst_req_q <= 1'b0;
    end else if (wdog_fire) begin
      wdog_q    <= 1'b0;
      rst_req_q <= 1'b1;
    end else begin
      rst_req_q <= 1'b0;
      if (wdog_wr_i) wdog_q <= wdata_i[0];
    end
  end

  assign ie_o      = ie_q;
  assign status_o  = status_q;
  assign wdog_o    = wdog_q;
  assign rst_req_o = rst_req_q;
endmodule

// File: rtl/ost_timer_core.sv
module ost_timer_core
  import ost_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_CH  = 4,
  parameter int ADDR_W  = 4,
  parameter int IE_W    = 12,
  parameter int WDOG_CH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rd_err_o,
  output logic [NUM_CH-1:0] irq_o,
  output logic              rst_req_o
);
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(WORD_COUNT);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(WORD_STATUS);
  localparam logic [ADDR_W-1:0] A_WDOG   = ADDR_W'(WORD_WDOG);
  localparam logic [ADDR_W-1:0] A_IEN    = ADDR_W'(WORD_IEN);

  logic [DATA_W-1:0]             cnt_q;
  logic [DATA_W-1:0]             step_val;
  logic                          step_en;
  logic                          cnt_ld;
  logic [NUM_CH-1:0][DATA_W-1:0] match_q;
  logic [NUM_CH-1:0]             hit_vec;
  logic [IE_W-1:0]               ie_q;
  logic [NUM_CH-1:0]             status_q;
  logic                          wdog_q;
  logic                          ie_wr, st_wr, wdog_wr;

  assign cnt_ld  = wr_en_i & (addr_i == A_COUNT);
  assign ie_wr   = wr_en_i & (addr_i == A_IEN);
  assign st_wr   = wr_en_i & (addr_i == A_STATUS);
  assign wdog_wr = wr_en_i & (addr_i == A_WDOG);

  ost_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick_i),
    .load_i     (cnt_ld),
    .load_val_i (wdata_i),
    .cnt_o      (cnt_q),
    .step_val_o (step_val),
    .step_en_o  (step_en)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic ch_wr;
    assign ch_wr = wr_en_i & (addr_i == ADDR_W'(g));
    ost_match_ch #(.DATA_W(DATA_W)) u_ch (
      .clk        (clk),
      .rst        (rst),
      .wr_i       (ch_wr),
      .wdata_i    (wdata_i),
      .step_val_i (step_val),
      .step_en_i  (step_en),
      .match_o    (match_q[g]),
      .hit_o      (hit_vec[g])
    );
  end

  ost_event_ctrl #(.NUM_CH(NUM_CH), .IE_W(IE_W), .WDOG_CH(WDOG_CH)) u_evt (
    .clk       (clk),
    .rst       (rst),
    .hit_i     (hit_vec),
    .ie_wr_i   (ie_wr),
    .st_wr_i   (st_wr),
    .wdog_wr_i (wdog_wr),
    .wdata_i   (wdata_i[IE_W-1:0]),
    .ie_o      (ie_q),
    .status_o  (status_q),
    .wdog_o    (wdog_q),
    .rst_req_o (rst_req_o)
  );

  // read path: decode, then one register stage
  logic [DATA_W-1:0] rd_mux;
  logic              rd_mapped;

  always_comb begin
    rd_mux    = '0;
    rd_mapped = 1'b1;
    if (addr_i == A_COUNT)       rd_mux = cnt_q;
    else if (addr_i == A_STATUS) rd_mux = DATA_W'(status_q);
    else if (addr_i == A_WDOG)   rd_mux = DATA_W'(wdog_q);
    else if (addr_i == A_IEN)    rd_mux = DATA_W'(ie_q);
    else begin
      rd_mapped = 1'b0;
      for (int i = 0; i < NUM_CH; i++) begin
        if (addr_i == ADDR_W'(i)) begin
          rd_mux    = match_q[i];
          rd_mapped = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o  <= '0;
      rd_err_o <= 1'b0;
    end else begin
      rdata_o  <= rd_en_i ? rd_mux : '0;
      rd_err_o <= rd_en_i & ~rd_mapped;
    end
  end

  assign irq_o = status_q;
endmodule

// File: rtl/ost_timer_chk.sv
module ost_timer_chk #(
  parameter int DATA_W  = 32,
  parameter int NUM_CH  = 4,
  parameter int IE_W    = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_i,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              rd_err_o,
  input logic [NUM_CH-1:0] irq_o,
  input logic              rst_req_o,
  input logic [DATA_W-1:0] cnt_q,
  input logic              cnt_ld,
  input logic [IE_W-1:0]   ie_q,
  input logic              ie_wr,
  input logic              st_wr,
  input logic [NUM_CH-1:0] hit_vec,
  input logic              wdog_q
);
  logic seen_q;
  always_ff @(posedge clk) begin
    if (rst) seen_q <= 1'b0;
    else     seen_q <= 1'b1;
  end

  p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
    (seen_q && $past(tick_i && !cnt_ld)) |-> (cnt_q == $past(cnt_q) + DATA_W'(1)));

  p_count_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (seen_q && $past(!tick_i && !cnt_ld)) |-> $stable(cnt_q));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    p_irq_gated_r3: assert property (@(posedge clk) disable iff (rst)
      (seen_q && $rose(irq_o[g])) |-> $past(ie_q[g] && hit_vec[g]));

    p_w1c_r5: assert property (@(posedge clk) disable iff (rst)
      (seen_q && $past(st_wr && wdata_i[g] && !hit_vec[g])) |-> !irq_o[g]);
  end

  p_ie_store_r6: assert property (@(posedge clk) disable iff (rst)
    (seen_q && $past(ie_wr)) |-> (ie_q == $past(wdata_i[IE_W-1:0])));

  p_req_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |=> !rst_req_o);

  p_req_disarm_r7: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |-> !wdog_q);

  p_err_after_read_r8: assert property (@(posedge clk) disable iff (rst)
    rd_err_o |-> (seen_q && $past(rd_en_i)));
endmodule

bind ost_timer_core ost_timer_chk #(
  .DATA_W (DATA_W),
  .NUM_CH (NUM_CH),
  .IE_W   (IE_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick_i    (tick_i),
  .rd_en_i   (rd_en_i),
  .wdata_i   (wdata_i),
  .rd_err_o  (rd_err_o),
  .irq_o     (irq_o),
  .rst_req_o (rst_req_o),
  .cnt_q     (cnt_q),
  .cnt_ld    (cnt_ld),
  .ie_q      (ie_q),
  .ie_wr     (ie_wr),
  .st_wr     (st_wr),
  .hit_vec   (hit_vec),
  .wdog_q    (wdog_q)
);

// File: tb/tb_ost_timer_core.sv
module tb_ost_timer_core;
  localparam int DW = 32;
  localparam int NC = 4;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick_i = 1'b0;
  logic          wr_en_i = 1'b0;
  logic          rd_en_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          rd_err_o;
  logic [NC-1:0] irq_o;
  logic          rst_req_o;

  int n_cmp = 0;
  int n_bad = 0;
  int n_req = 0;

  always #10 clk = ~clk;

  ost_timer_core dut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .rd_err_o(rd_err_o),
    .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  always @(negedge clk) if (!rst && rst_req_o) n_req++;

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input int a, input logic [DW-1:0] d);
    wr_en_i = 1'b1; addr_i = AW'(a); wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic bus_rd(input int a, output logic [DW-1:0] d, output logic e);
    rd_en_i = 1'b1; addr_i = AW'(a);
    @(negedge clk);
    rd_en_i = 1'b0;
    d = rdata_o; e = rd_err_o;
  endtask

  task automatic ticks(input int k);
    tick_i = 1'b1;
    repeat (k) @(negedge clk);
    tick_i = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    logic e;
    logic [DW-1:0] t;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state of every word and output
    for (int a = 0; a < 8; a++) begin
      bus_rd(a, d, e);
      check($sformatf("R1 reset word %0d", a), d, '0);
    end
    check("R1 irq after reset", DW'(irq_o), '0);
    check("R1 reset request after reset", DW'(rst_req_o), '0);

    // R9: compare registers at words 0..3, read one cycle after strobe
    for (int c = 0; c < NC; c++) bus_wr(c, 32'hA5A5_0000 + DW'(c * 3 + 1));
    for (int c = 0; c < NC; c++) begin
      bus_rd(c, d, e);
      check($sformatf("R9 compare %0d readback", c), d, 32'hA5A5_0000 + DW'(c * 3 + 1));
      check("R8 mapped read error flag", DW'(e), '0);
    end

    // R6: only bits 11:0 of the enable word are kept
    bus_wr(7, 32'hFFFF_FFFF);
    bus_rd(7, d, e);
    check("R6 enable width", d, 32'h0000_0FFF);

    // R8: unmapped words read zero with error flag
    for (int a = 8; a < 16; a++) begin
      bus_rd(a, d, e);
      check($sformatf("R8 unmapped word %0d data", a), d, '0);
      check($sformatf("R8 unmapped word %0d flag", a), DW'(e), 32'd1);
    end

    // R2: load and count
    bus_wr(4, 32'h7FFF_FFF0);
    bus_rd(4, d, e);
    check("R2 counter load", d, 32'h7FFF_FFF0);
    ticks(37);
    bus_rd(4, d, e);
    check("R2 counter after 37 ticks", d, 32'h7FFF_FFF0 + 32'd37);
    repeat (5) @(negedge clk);
    bus_rd(4, d, e);
    check("R2 counter holds without tick", d, 32'h7FFF_FFF0 + 32'd37);

    // R3: sweep each channel against every low enable pattern
    for (int c = 0; c < NC; c++) begin
      for (int p = 0; p < 16; p++) begin
        t = 32'h1000_0000 + DW'(c * 32 + p);
        for (int j = 0; j < NC; j++) bus_wr(j, (j == c) ? t : t + 32'h8000);
        bus_wr(7, DW'(p));
        bus_wr(5, 32'hF);
        bus_wr(4, t - 32'd2);
        ticks(2);
        bus_rd(5, d, e);
        check($sformatf("R3 status ch%0d ie=%0h", c, p), d, p[c] ? DW'(1 << c) : '0);
        check($sformatf("R3 irq ch%0d ie=%0h", c, p), DW'(irq_o), p[c] ? DW'(1 << c) : '0);
      end
    end

    // R2/R3: wrap from all ones onto compare value zero
    bus_wr(0, 32'h0);
    for (int j = 1; j < NC; j++) bus_wr(j, 32'h5555_0000);
    bus_wr(7, 32'h1);
    bus_wr(5, 32'hF);
    bus_wr(4, 32'hFFFF_FFFF);
    ticks(1);
    bus_rd(4, d, e);
    check("R2 wrap to zero", d, '0);
    bus_rd(5, d, e);
    check("R3 match after wrap", d, 32'h1);

    // R4: once per equality; resting, later ticks and direct load do not fire
    bus_wr(5, 32'h1);
    repeat (4) @(negedge clk);
    ticks(10);
    bus_rd(5, d, e);
    check("R4 no refire after equality", d, '0);
    bus_wr(4, 32'h0);
    repeat (3) @(negedge clk);
    bus_rd(5, d, e);
    check("R4 load onto compare value does not fire", d, '0);

    // R5: partial clear by ones
    for (int j = 0; j < NC; j++) bus_wr(j, 32'h2000_0000);
    bus_wr(7, 32'hF);
    bus_wr(4, 32'h1FFF_FFFF);
    ticks(1);
    bus_rd(5, d, e);
    check("R5 all four set", d, 32'hF);
    bus_wr(5, 32'h5);
    bus_rd(5, d, e);
    check("R5 partial clear status", d, 32'hA);
    check("R5 partial clear irq", DW'(irq_o), 32'hA);

    // R5: event in the same cycle as a clear keeps the bit
    bus_wr(5, 32'hF);
    bus_wr(4, 32'h1FFF_FFFF);
    tick_i = 1'b1; wr_en_i = 1'b1; addr_i = AW'(5); wdata_i = 32'h1;
    @(negedge clk);
    tick_i = 1'b0; wr_en_i = 1'b0; wdata_i = '0;
    bus_rd(5, d, e);
    check("R5 set wins over clear", d, 32'hF);
    bus_wr(5, 32'hF);

    // R7: watchdog fire, pulse, disarm, no second request
    for (int j = 0; j < NC; j++) bus_wr(j, (j == 3) ? 32'h3000_0000 : 32'h3100_0000);
    bus_wr(7, 32'h0);
    bus_wr(6, 32'h1);
    bus_rd(6, d, e);
    check("R9 watchdog word armed", d, 32'h1);
    n_req = 0;
    bus_wr(4, 32'h2FFF_FFFF);
    ticks(1);
    repeat (3) @(negedge clk);
    check("R7 one request pulse", DW'(n_req), 32'd1);
    bus_rd(6, d, e);
    check("R7 watchdog disarmed", d, '0);
    bus_rd(5, d, e);
    check("R7 no status without enable", d, '0);
    bus_wr(4, 32'h2FFF_FFFF);
    ticks(1);
    repeat (3) @(negedge clk);
    check("R7 no request when disarmed", DW'(n_req), 32'd1);

    // R7: other channel match with watchdog armed issues nothing
    bus_wr(6, 32'h1);
    bus_wr(0, 32'h4000_0000);
    bus_wr(4, 32'h3FFF_FFFF);
    ticks(1);
    repeat (3) @(negedge clk);
    check("R7 channel 0 does not request", DW'(n_req), 32'd1);
    bus_rd(6, d, e);
    check("R7 still armed", d, 32'h1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule